// File: doc/BRIEF.md
# Programmable Address Window Decoder

This block sits on the request path of a DMA-style engine. It compares each issued address against a small set of programmable address windows, five by default. Each window has a base register and a size mask. The base register also carries an attribute byte, which selects a chip select or target inside the memory system, and a small target identifier. A shared control word holds one enable bit for each window. The upper half of the same word holds a two-bit access permission for each window.

For every request the decoder returns a registered response one cycle later. The response gives a hit flag, the index of the winning window, its target identifier, its attribute byte and a permission verdict. It raises a decode error for a miss or for a forbidden access. An override register can replace the upper address half used for decoding. Software programs everything through a simple word-indexed write/read port: index 0 is control, index 1 is override, index 2+2i is the base of window i and index 3+2i is the mask of window i.

Top module: `addr_window_decoder`

## Requirements
- R1: After reset every register reads as zero, and a request gets no hit and raises the decode error.
- R2: Writes store only the implemented bits, and reads return them with all other bits zero. The implemented bits are: control bits [4:0] and [25:16]; override bits [31:16] and [0]; base bits [31:8] and [3:0]; mask bits [31:16]. Indices 12 to 15 ignore writes and read zero.
- R3: Window i matches when (decode_addr[31:16] & ~mask[31:16]) equals base[31:16].
- R4: A window whose enable bit (control bit i) is clear never matches.
- R5: When several enabled windows match, the lowest index wins.
- R6: On a hit, rsp_win gives the window index, rsp_attr gives base[15:8] and rsp_target gives base[3:0].
- R7: The permission field of window i is at control bits [17+2i:16+2i]. Its low bit allows reads and its high bit allows writes, so the value 3 grants full access. rsp_allow reports whether the access type is permitted.
- R8: rsp_err is set for a valid request that misses or is not allowed.
- R9: The response appears exactly one cycle after req_valid. When there is no request, all response outputs are zero. On a miss, rsp_win, rsp_attr, rsp_target and rsp_allow are zero.
- R10: When override bit 0 is set, the decode uses {override[31:16], req_addr[15:0]} in place of req_addr.
- R11: A register write and a request in the same cycle: the request is decoded with the register contents from before the write, and the write takes effect for the next request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 4 | Register word index |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data (combinational) |
| req_valid | input | 1 | Request present |
| req_addr | input | 32 | Request address |
| req_write | input | 1 | 1 for a write access, 0 for a read access |
| rsp_valid | output | 1 | Response present |
| rsp_hit | output | 1 | A window matched |
| rsp_win | output | 3 | Index of the winning window |
| rsp_target | output | 4 | Target identifier of the winning window |
| rsp_attr | output | 8 | Attribute byte of the winning window |
| rsp_allow | output | 1 | Access type permitted |
| rsp_err | output | 1 | Decode error: miss or forbidden access |

## Verification
A register write and an address decode can fall in the same cycle. This is the case where a window is being reprogrammed while the engine is still issuing requests. The bench provokes it by driving a write and a request on the same edge. One case moves a window away from the request address. Another case enables a window that would match. The bench expects the response to reflect the old contents, then sends the same request again in the next cycle and expects the new contents. Random stimulus also places a write beside many requests, and its expected values come from a shadow copy of the registers.

// File: rtl/addr_window_decoder.sv
module addr_window_decoder #(
  parameter int NUM_WIN = 5,
  localparam int IW = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1,
  localparam int RAW = $clog2(2 * NUM_WIN + 2)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cfg_we,
  input  logic [RAW-1:0] cfg_addr,
  input  logic [31:0]    cfg_wdata,
  output logic [31:0]    cfg_rdata,
  input  logic           req_valid,
  input  logic [31:0]    req_addr,
  input  logic           req_write,
  output logic           rsp_valid,
  output logic           rsp_hit,
  output logic [IW-1:0]  rsp_win,
  output logic [3:0]     rsp_target,
  output logic [7:0]     rsp_attr,
  output logic           rsp_allow,
  output logic           rsp_err
);

  logic [NUM_WIN-1:0]   win_en;
  logic [2*NUM_WIN-1:0] win_perm;
  logic                 ovr_en;
  logic [15:0]          ovr_hi;
  logic [15:0]          base_hi  [NUM_WIN];
  logic [7:0]           base_attr[NUM_WIN];
  logic [3:0]           base_tgt [NUM_WIN];
  logic [15:0]          mask_hi  [NUM_WIN];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_en   <= '0;
      win_perm <= '0;
      ovr_en   <= 1'b0;
      ovr_hi   <= '0;
      for (int i = 0; i < NUM_WIN; i++) begin
        base_hi[i]   <= '0;
        base_attr[i] <= '0;
        base_tgt[i]  <= '0;
        mask_hi[i]   <= '0;
      end
    end else if (cfg_we) begin
      if (cfg_addr == RAW'(0)) begin
        win_en   <= cfg_wdata[NUM_WIN-1:0];
        win_perm <= cfg_wdata[16 +: 2*NUM_WIN];
      end
      if (cfg_addr == RAW'(1)) begin
        ovr_en <= cfg_wdata[0];
        ovr_hi <= cfg_wdata[31:16];
      end
      for (int i = 0; i < NUM_WIN; i++) begin
        if (cfg_addr == RAW'(2 + 2*i)) begin
          base_hi[i]   <= cfg_wdata[31:16];
          base_attr[i] <= cfg_wdata[15:8];
          base_tgt[i]  <= cfg_wdata[3:0];
        end
        if (cfg_addr == RAW'(3 + 2*i))
          mask_hi[i] <= cfg_wdata[31:16];
      end
    end
  end

  always_comb begin
    cfg_rdata = '0;
    if (cfg_addr == RAW'(0)) begin
      cfg_rdata[NUM_WIN-1:0]     = win_en;
      cfg_rdata[16 +: 2*NUM_WIN] = win_perm;
    end
    if (cfg_addr == RAW'(1))
      cfg_rdata = {ovr_hi, 15'd0, ovr_en};
    for (int i = 0; i < NUM_WIN; i++) begin
      if (cfg_addr == RAW'(2 + 2*i))
        cfg_rdata = {base_hi[i], base_attr[i], 4'd0, base_tgt[i]};
      if (cfg_addr == RAW'(3 + 2*i))
        cfg_rdata = {mask_hi[i], 16'd0};
    end
  end

  wire [15:0] dec_hi = ovr_en ? ovr_hi : req_addr[31:16];

  logic [NUM_WIN-1:0] match;
  logic               found;
  logic [IW-1:0]      sel;
  logic [1:0]         sel_perm;

  always_comb begin
    found    = 1'b0;
    sel      = '0;
    sel_perm = '0;
    for (int i = 0; i < NUM_WIN; i++) begin
      match[i] = win_en[i] && ((dec_hi & ~mask_hi[i]) == base_hi[i]);
      if (match[i] && !found) begin
        found    = 1'b1;
        sel      = IW'(i);
        sel_perm = win_perm[2*i +: 2];
      end
    end
  end

  wire hit_now   = req_valid && found;
  wire allow_now = hit_now && (req_write ? sel_perm[1] : sel_perm[0]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid  <= 1'b0;
      rsp_hit    <= 1'b0;
      rsp_win    <= '0;
      rsp_target <= '0;
      rsp_attr   <= '0;
      rsp_allow  <= 1'b0;
      rsp_err    <= 1'b0;
    end else begin
      rsp_valid  <= req_valid;
      rsp_hit    <= hit_now;
      rsp_win    <= hit_now ? sel : '0;
      rsp_target <= hit_now ? base_tgt[sel] : '0;
      rsp_attr   <= hit_now ? base_attr[sel] : '0;
      rsp_allow  <= allow_now;
      rsp_err    <= req_valid && !allow_now;
    end
  end

  // R8
  err_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_err |-> rsp_valid);

  // R7
  allow_needs_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_allow |-> (rsp_hit && !rsp_err));

  // R9
  rsp_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);

  // R9
  miss_fields_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_hit |-> (rsp_win == '0 && rsp_attr == '0 && rsp_target == '0));

  // R4
  all_disabled_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (win_en == '0) |=> !rsp_hit);

  // R6
  win_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_hit |-> (int'(rsp_win) < NUM_WIN));

endmodule

// File: tb/sim_addr_window_decoder.sv
module sim_addr_window_decoder;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_we = 1'b0;
  logic [3:0] cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic req_valid = 1'b0;
  logic [31:0] req_addr = '0;
  logic req_write = 1'b0;
  logic rsp_valid, rsp_hit, rsp_allow, rsp_err;
  logic [2:0] rsp_win;
  logic [3:0] rsp_target;
  logic [7:0] rsp_attr;

  int checks = 0;
  int errors = 0;

  logic [31:0] sh_ctrl, sh_ovr;
  logic [31:0] sh_base[5];
  logic [31:0] sh_mask[5];

  always #2 clk = ~clk;

  addr_window_decoder u0 (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .req_valid(req_valid),
    .req_addr(req_addr), .req_write(req_write), .rsp_valid(rsp_valid),
    .rsp_hit(rsp_hit), .rsp_win(rsp_win), .rsp_target(rsp_target),
    .rsp_attr(rsp_attr), .rsp_allow(rsp_allow), .rsp_err(rsp_err));

  function automatic logic [31:0] keep_bits(input logic [3:0] a, input logic [31:0] d);
    if (a == 0) return d & 32'h03FF001F;
    if (a == 1) return d & 32'hFFFF0001;
    if (a >= 12) return 32'h0;
    if (a[0] == 1'b0) return d & 32'hFFFFFF0F;
    return d & 32'hFFFF0000;
  endfunction

  function automatic logic [31:0] shadow_rd(input logic [3:0] a);
    if (a == 0) return sh_ctrl;
    if (a == 1) return sh_ovr;
    if (a >= 12) return 32'h0;
    if (a[0] == 1'b0) return sh_base[(a - 2) / 2];
    return sh_mask[(a - 3) / 2];
  endfunction

  task automatic shadow_wr(input logic [3:0] a, input logic [31:0] d);
    logic [31:0] k;
    k = keep_bits(a, d);
    if (a == 0) sh_ctrl = k;
    else if (a == 1) sh_ovr = k;
    else if (a < 12) begin
      if (a[0] == 1'b0) sh_base[(a - 2) / 2] = k;
      else sh_mask[(a - 3) / 2] = k;
    end
  endtask

  // {err, allow, hit, win[2:0], target[3:0], attr[7:0]}
  function automatic logic [17:0] expect_rsp(input logic v, input logic [31:0] a, input logic w);
    logic [15:0] hi;
    logic found;
    int idx;
    logic [1:0] perm;
    logic ok;
    hi = sh_ovr[0] ? sh_ovr[31:16] : a[31:16];
    found = 1'b0;
    idx = 0;
    for (int i = 0; i < 5; i++)
      if (!found && sh_ctrl[i] && ((hi & ~sh_mask[i][31:16]) == sh_base[i][31:16])) begin
        found = 1'b1;
        idx = i;
      end
    if (!v) return 18'h0;
    if (!found) return {1'b1, 17'h0};
    perm = sh_ctrl[16 + 2*idx +: 2];
    ok = w ? perm[1] : perm[0];
    return {!ok, ok, 1'b1, 3'(idx), sh_base[idx][3:0], sh_base[idx][15:8]};
  endfunction

  task automatic check_rsp(input logic [17:0] e, input logic ev, input string tag);
    logic [18:0] act, exp;
    act = {rsp_valid, rsp_err, rsp_allow, rsp_hit, rsp_win, rsp_target, rsp_attr};
    exp = {ev, e};
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s rsp actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(posedge clk); #1;
    cfg_we = 1'b0;
    shadow_wr(a, d);
  endtask

  task automatic rd(input logic [3:0] a, input string tag);
    @(negedge clk);
    cfg_addr = a;
    #1;
    checks++;
    if (cfg_rdata !== shadow_rd(a)) begin
      errors++;
      $display("FAIL %s rdata[%0d] actual=%h expected=%h", tag, a, cfg_rdata, shadow_rd(a));
    end
  endtask

  task automatic rq(input logic v, input logic [31:0] a, input logic w, input string tag);
    logic [17:0] e;
    @(negedge clk);
    req_valid = v; req_addr = a; req_write = w;
    e = expect_rsp(v, a, w);
    @(posedge clk); #1;
    req_valid = 1'b0;
    check_rsp(e, v, tag);
  endtask

  task automatic wr_and_rq(input logic [3:0] ca, input logic [31:0] d,
                           input logic [31:0] a, input logic w, input string tag);
    logic [17:0] e;
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = ca; cfg_wdata = d;
    req_valid = 1'b1; req_addr = a; req_write = w;
    e = expect_rsp(1'b1, a, w);
    @(posedge clk); #1;
    cfg_we = 1'b0; req_valid = 1'b0;
    shadow_wr(ca, d);
    check_rsp(e, 1'b1, tag);
  endtask

  initial begin
    #(4 * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] seed;
    logic [7:0] attrs[5];
    seed = $urandom(32'h5EED_0123);
    attrs[0] = 8'h0E; attrs[1] = 8'h0D; attrs[2] = 8'h0B; attrs[3] = 8'h07; attrs[4] = 8'h1F;
    sh_ctrl = '0; sh_ovr = '0;
    for (int i = 0; i < 5; i++) begin sh_base[i] = '0; sh_mask[i] = '0; end

    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1 reset state
    for (int a = 0; a < 16; a++) rd(4'(a), "R1");
    rq(1'b1, 32'h0000_0000, 1'b0, "R1");
    rq(1'b1, 32'h1234_5678, 1'b1, "R1");

    // R2 implemented bits only, unmapped indices
    for (int a = 0; a < 16; a++) begin
      wr(4'(a), 32'hFFFF_FFFF);
      rd(4'(a), "R2");
    end
    for (int a = 0; a < 16; a++) wr(4'(a), 32'h0);
    rd(4'd0, "R2");

    // R9 no request gives all-zero response
    rq(1'b0, 32'h0, 1'b0, "R9");

    // R3 R6 two-gigabyte window at zero, CS0 attribute, full access
    wr(4'd2, 32'h0000_0E05);
    wr(4'd3, 32'h7FFF_0000);
    wr(4'd0, 32'h0003_0001);
    rq(1'b1, 32'h0000_0000, 1'b0, "R3");
    rq(1'b1, 32'h7FFF_FFFC, 1'b1, "R6");
    rq(1'b1, 32'h8000_0000, 1'b0, "R3 miss");

    // R5 overlapping windows, one-megabyte window 1 inside window 0
    wr(4'd4, 32'h0010_0D03);
    wr(4'd5, 32'h000F_0000);
    wr(4'd0, 32'h000F_0003);
    rq(1'b1, 32'h0012_3456, 1'b0, "R5");
    // R4 disable window 0, window 1 now wins
    wr(4'd0, 32'h000F_0002);
    rq(1'b1, 32'h0012_3456, 1'b0, "R4");
    rq(1'b1, 32'h0020_0000, 1'b0, "R4 miss");

    // R7 R8 each permission value, read and write
    for (int p = 0; p < 4; p++) begin
      wr(4'd0, (32'(p) << 18) | 32'h2);
      rq(1'b1, 32'h001A_0000, 1'b0, "R7");
      rq(1'b1, 32'h001A_0000, 1'b1, "R8");
    end

    // R10 override steers the upper address half
    wr(4'd0, 32'h0003_C002 | 32'h000C_0000);
    wr(4'd1, 32'h0015_0001);
    rq(1'b1, 32'h9999_0004, 1'b0, "R10");
    wr(4'd1, 32'h0015_0000);
    rq(1'b1, 32'h9999_0004, 1'b0, "R10 off");

    // R11 write and request on the same edge
    wr_and_rq(4'd4, 32'h0200_0D03, 32'h0010_0000, 1'b0, "R11 old");
    rq(1'b1, 32'h0010_0000, 1'b0, "R11 new");
    wr(4'd2, 32'h0000_0E05);
    wr(4'd0, 32'h000C_0002);
    wr_and_rq(4'd0, 32'h000F_0003, 32'h0300_0000, 1'b0, "R11 enable old");
    rq(1'b1, 32'h0300_0000, 1'b0, "R11 enable new");

    // random configurations and requests
    for (int cfg = 0; cfg < 10; cfg++) begin
      for (int i = 0; i < 5; i++) begin
        logic [15:0] m;
        m = 16'((32'h1 << ($urandom % 16)) - 1);
        wr(4'(3 + 2*i), {m, 16'($urandom)});
        wr(4'(2 + 2*i), {16'($urandom) & ~m, attrs[i], 8'($urandom)});
      end
      wr(4'd0, $urandom);
      wr(4'd1, ($urandom % 4 == 0) ? $urandom : 32'h0);
      for (int n = 0; n < 40; n++) begin
        logic [31:0] a;
        int j;
        j = $urandom % 5;
        if (n % 2 == 0)
          a = {sh_base[j][31:16] | (16'($urandom) & sh_mask[j][31:16]), 16'($urandom)};
        else
          a = $urandom;
        if (n % 9 == 4)
          wr_and_rq(4'($urandom % 12), $urandom, a, 1'($urandom), "R11 rand");
        else
          rq(1'($urandom % 8 != 0), a, 1'($urandom), "R3 R5 R7 rand");
      end
      for (int a = 0; a < 12; a++) rd(4'(a), "R2 rand");
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule